// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a stream of oscillator tick enables (nominally 32768 per second) into a single-cycle seconds pulse. A small signed trim code applies a frequency correction of up to ±30 ppm in 10 ppm steps. The block does not change the divider by a fixed amount. Each second it adds the requested fraction of a count to a remainder accumulator, and it moves exactly one count into or out of a second only when that accumulator wraps. Over a long run, the average length of a second then matches the trimmed rate to within one count.

The trim code is taken at each second boundary. A debug output shows the terminal count in force for the second now running, so firmware or a test can see the correction at work. The oscillator itself, the calendar above this block and the storage of the trim code belong to other blocks.

Top module: `trimsec_prescaler`

## Requirements
- R1: While reset is held and just after it, `sec_pulse` is 0 and `term_dbg` equals the nominal tick count (parameter `NOMINAL_TICKS`).
- R2: With trim code 0, every second lasts exactly `NOMINAL_TICKS` accepted ticks.
- R3: Trim code encoding: bit 2 is the sign (0 = speed up, 1 = slow down), bit 1 weighs 20 ppm and bit 0 weighs 10 ppm, and the magnitude is the sum of the set weights.
- R4: With a positive code of magnitude M ppm, each boundary adds M·NOMINAL_TICKS to an accumulator kept modulo `PPM_SCALE`. The next second is one tick shorter exactly when that addition wraps, and otherwise it is nominal.
- R5: With a negative code, the same accumulator rule makes the next second one tick longer on each wrap.
- R6: A code with the sign set and both magnitude bits clear behaves exactly like code 0.
- R7: The trim code is sampled only at a second boundary. Changing it mid-second does not alter the length of the second in progress, and `term_dbg` changes only together with a seconds pulse.
- R8: `sec_pulse` is high for one clock cycle, in the cycle after the tick that completes the terminal count. Cycles without `tick_en` do not advance the count.
- R9: Over S seconds at a fixed code of M ppm, the total number of ticks equals S·NOMINAL_TICKS·(1 ∓ M/PPM_SCALE) within one count.
- R10: `term_dbg` always stays within one count of the nominal tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One oscillator tick accepted on this clock edge |
| trim_code | input | MAG_BITS+1 | Sign bit on top, magnitude bits below |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |
| term_dbg | output | CNT_W | Terminal tick count of the current second |

## Verification
The checker enforces on every cycle that the pulse is one cycle wide and follows an accepted tick, and that the terminal count stays within one tick of nominal. It also enforces that the terminal count changes only with a pulse and moves in the direction set by the sampled sign bit, and that zero-magnitude codes leave it nominal. What the assertions cannot show is the exact position of each wrap in the accumulator sequence, whether a trim written mid-second waits for the boundary, and the long-run average. The bench scenarios establish these by counting ticks between pulses against an independent model, and by totalling ticks over a thousand seconds.

// File: rtl/trimsec_pkg.sv
package trimsec_pkg;
   typedef enum logic [1:0] {
      ADJ_NONE  = 2'd0,
      ADJ_SHORT = 2'd1,
      ADJ_LONG  = 2'd2
   } adj_e;
endpackage

// File: rtl/trimsec_decode.sv
module trimsec_decode #(
   parameter int MAG_BITS = 2,
   parameter int STEP_PPM = 10,
   parameter int PPM_W    = 6
) (
   input  logic [MAG_BITS:0]  code,
   output logic               neg,
   output logic [PPM_W-1:0]   ppm
);
   logic [PPM_W-1:0] part [MAG_BITS+1];

   assign part[0] = '0;

   // each magnitude bit i carries weight STEP_PPM * 2^i
   for (genvar i = 0; i < MAG_BITS; i++) begin : g_weight
      localparam int WEIGHT = STEP_PPM << i;
      assign part[i+1] = part[i] + (code[i] ? PPM_W'(WEIGHT) : '0);
   end

   assign ppm = part[MAG_BITS];
   assign neg = code[MAG_BITS];
endmodule

// File: rtl/trimsec_accum.sv
module trimsec_accum
   import trimsec_pkg::*;
#(
   parameter int NOMINAL = 32768,
   parameter int SCALE   = 1000000,
   parameter int PPM_W   = 6,
   parameter int ACC_W   = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             neg,
   input  logic [PPM_W-1:0] ppm,
   output adj_e             adj
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] inc;
   logic [ACC_W-1:0] sum;
   logic             wrap;

   always_comb begin
      inc  = ACC_W'(ppm) * ACC_W'(NOMINAL);
      sum  = acc_q + inc;
      wrap = (sum >= ACC_W'(SCALE));
      if (!wrap)
         adj = ADJ_NONE;
      else if (neg)
         adj = ADJ_LONG;
      else
         adj = ADJ_SHORT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (step)
         acc_q <= wrap ? (sum - ACC_W'(SCALE)) : sum;
   end
endmodule

// File: rtl/trimsec_counter.sv
module trimsec_counter
   import trimsec_pkg::*;
#(
   parameter int NOMINAL = 32768,
   parameter int CNT_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  adj_e             adj,
   output logic             boundary,
   output logic             pulse,
   output logic [CNT_W-1:0] term
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_nxt;

   assign boundary = tick_en && (cnt_q == term - CNT_W'(1));

   always_comb begin
      unique case (adj)
         ADJ_SHORT: term_nxt = CNT_W'(NOMINAL - 1);
         ADJ_LONG:  term_nxt = CNT_W'(NOMINAL + 1);
         default:   term_nxt = CNT_W'(NOMINAL);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         term  <= CNT_W'(NOMINAL);
         pulse <= 1'b0;
      end else begin
         pulse <= boundary;
         if (boundary) begin
            cnt_q <= '0;
            term  <= term_nxt;
         end else if (tick_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/trimsec_prescaler.sv
module trimsec_prescaler
   import trimsec_pkg::*;
#(
   parameter int NOMINAL_TICKS = 32768,
   parameter int PPM_SCALE     = 1000000,
   parameter int STEP_PPM      = 10,
   parameter int MAG_BITS      = 2,
   localparam int TRIM_W       = MAG_BITS + 1,
   localparam int CNT_W        = $clog2(NOMINAL_TICKS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [TRIM_W-1:0] trim_code,
   output logic              sec_pulse,
   output logic [CNT_W-1:0]  term_dbg
);
   localparam int MAX_PPM = STEP_PPM * ((1 << MAG_BITS) - 1);
   localparam int PPM_W   = $clog2(MAX_PPM + 1) + 1;
   localparam int ACC_W   = $clog2(2 * PPM_SCALE) + 1;

   if (NOMINAL_TICKS < 2) begin : g_bad_nominal
      $error("NOMINAL_TICKS must be at least 2");
   end
   if (MAG_BITS < 1) begin : g_bad_mag
      $error("MAG_BITS must be at least 1");
   end
   if (MAX_PPM * NOMINAL_TICKS >= PPM_SCALE) begin : g_bad_range
      $error("full-scale trim must add less than one count per second");
   end

   logic             neg;
   logic [PPM_W-1:0] ppm;
   logic             boundary;
   adj_e             adj;

   trimsec_decode #(
      .MAG_BITS (MAG_BITS),
      .STEP_PPM (STEP_PPM),
      .PPM_W    (PPM_W)
   ) u_decode (
      .code (trim_code),
      .neg  (neg),
      .ppm  (ppm)
   );

   trimsec_accum #(
      .NOMINAL (NOMINAL_TICKS),
      .SCALE   (PPM_SCALE),
      .PPM_W   (PPM_W),
      .ACC_W   (ACC_W)
   ) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (boundary),
      .neg   (neg),
      .ppm   (ppm),
      .adj   (adj)
   );

   trimsec_counter #(
      .NOMINAL (NOMINAL_TICKS),
      .CNT_W   (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .adj      (adj),
      .boundary (boundary),
      .pulse    (sec_pulse),
      .term     (term_dbg)
   );
endmodule

// File: rtl/trimsec_checker.sv
module trimsec_checker #(
   parameter int NOMINAL = 32768,
   parameter int CNT_W   = 16,
   parameter int TRIM_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic [TRIM_W-1:0] trim_code,
   input logic              sec_pulse,
   input logic [CNT_W-1:0]  term_dbg
);
   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse);

   assert_pulse_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_pulse) |-> $past(tick_en));

   assert_term_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (term_dbg >= CNT_W'(NOMINAL - 1)) && (term_dbg <= CNT_W'(NOMINAL + 1)));

   assert_term_only_at_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(term_dbg) |-> sec_pulse);

   assert_zero_mag_nominal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && ($past(trim_code[TRIM_W-2:0]) == '0)) |-> (term_dbg == CNT_W'(NOMINAL)));

   assert_positive_shortens_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !$past(trim_code[TRIM_W-1])) |-> (term_dbg <= CNT_W'(NOMINAL)));

   assert_negative_lengthens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && $past(trim_code[TRIM_W-1])) |-> (term_dbg >= CNT_W'(NOMINAL)));
endmodule

bind trimsec_prescaler trimsec_checker #(
   .NOMINAL (NOMINAL_TICKS),
   .CNT_W   (CNT_W),
   .TRIM_W  (TRIM_W)
) u_trimsec_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .trim_code (trim_code),
   .sec_pulse (sec_pulse),
   .term_dbg  (term_dbg)
);

// File: tb/tb_trimsec_prescaler.sv
module tb_trimsec_prescaler;
   localparam int N     = 16;
   localparam int SCALE = 1000;
   localparam int CW    = $clog2(N + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic [2:0]    trim_code = 3'd0;
   logic          sec_pulse;
   logic [CW-1:0] term_dbg;

   int n_checks = 0;
   int n_fail = 0;
   int exp_q[$];
   int meas = 0;
   int model_acc = 0;
   int sec_count = 0;
   longint total_ticks = 0;
   bit tick_run = 1'b0;
   bit prev_pulse = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   always #10 clk = ~clk;

   trimsec_prescaler #(
      .NOMINAL_TICKS (N),
      .PPM_SCALE     (SCALE),
      .STEP_PPM      (10),
      .MAG_BITS      (2)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .trim_code (trim_code),
      .sec_pulse (sec_pulse),
      .term_dbg  (term_dbg)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R3: bit2 sign, bit1 = 20 ppm, bit0 = 10 ppm
   function automatic int code_ppm(input logic [2:0] c);
      return (c[1] ? 20 : 0) + (c[0] ? 10 : 0);
   endfunction

   // tick stimulus: about three ticks in four cycles
   always @(posedge clk) begin
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick_en = tick_run && (lfsr[1:0] != 2'b00);
   end

   // monitor and scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (sec_pulse) begin
            int e;
            int inc;
            int nxt;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            chk(meas == e, "R2/R4/R5 second length", meas, e);
            chk(!prev_pulse, "R8 pulse width", prev_pulse, 0);
            total_ticks += meas;
            meas = 0;
            sec_count++;
            inc = code_ppm(trim_code) * N;
            model_acc += inc;
            nxt = N;
            if (model_acc >= SCALE) begin
               model_acc -= SCALE;
               nxt = trim_code[2] ? N + 1 : N - 1;
            end
            exp_q.push_back(nxt);
            chk(int'(term_dbg) == nxt, "R10 term_dbg next", term_dbg, nxt);
         end
         if (tick_en) meas++;
         prev_pulse = sec_pulse;
      end
   end

   task automatic do_reset(input logic [2:0] code);
      tick_run = 1'b0;
      @(posedge clk); #3;
      rst_n = 1'b0;
      trim_code = code;
      repeat (3) @(posedge clk);
      #5;
      chk(sec_pulse == 1'b0, "R1 pulse in reset", sec_pulse, 0);
      chk(int'(term_dbg) == N, "R1 term in reset", term_dbg, N);
      exp_q.delete();
      exp_q.push_back(N);
      model_acc = 0;
      meas = 0;
      prev_pulse = 1'b0;
      total_ticks = 0;
      sec_count = 0;
      rst_n = 1'b1;
      tick_run = 1'b1;
   endtask

   task automatic run_seconds(input int n);
      int target;
      target = sec_count + n;
      wait (sec_count >= target);
   endtask

   initial begin
      do_reset(3'd0);
      // R1: state just after reset, before any tick counts up a second
      @(negedge clk);
      chk(sec_pulse == 1'b0, "R1 after reset", sec_pulse, 0);
      run_seconds(10);

      // every code, including the negative-zero code (R6), R4 and R5
      for (int c = 0; c < 8; c++) begin
         do_reset(3'(c));
         run_seconds(40);
      end

      // R7: mid-second code changes take effect at the next boundary
      do_reset(3'b000);
      run_seconds(5);
      repeat (6) @(posedge clk);
      #3 trim_code = 3'b011;
      run_seconds(20);
      repeat (5) @(posedge clk);
      #3 trim_code = 3'b111;
      run_seconds(20);
      repeat (7) @(posedge clk);
      #3 trim_code = 3'b100;
      run_seconds(8);

      // R9: long-run averages at full scale
      do_reset(3'b011);
      run_seconds(1000);
      chk((total_ticks >= 15519) && (total_ticks <= 15521), "R9 +30ppm total", total_ticks, 15520);
      do_reset(3'b111);
      run_seconds(1000);
      chk((total_ticks >= 16479) && (total_ticks <= 16481), "R9 -30ppm total", total_ticks, 16480);
      do_reset(3'b100);
      run_seconds(200);
      chk(total_ticks == 3200, "R6 negative zero total", total_ticks, 3200);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule